// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a memory-mapped model of a parallel NOR flash part that is driven by a command-set state machine. A small register array stands in for the flash cells. Each bus write is taken either as a command byte or as data, depending on which step of a multi-write sequence the interpreter has reached. The active command decides what a bus read returns: array contents, the status byte, identifier words or bytes of the query table.

The interpreter covers these operations: single-word program, sector erase with a confirm write, buffered program with a word count and a confirm write, status clear, the lock and unlock sequences, status read, identifier read and query read. Program and erase take effect in one clock. There is no modelled busy time, so the ready bit is always reported as set. A write-protect input blocks changes to the array and makes the interpreter report an error instead.

The bus has a word address, a 16-bit data port, and single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, reads return array data, every array word reads 0xFFFF, and the status byte is 0x80 (bit 7 is the ready bit).
- R2: In array mode, a read returns the word at address modulo DEPTH on `rdata` in the cycle after `rd_en`. `rdata` keeps its value in every cycle without `rd_en`, including cycles with writes.
- R3: A write whose low byte is 0x10 or 0x40, followed by any second write, stores the second write's data at the second write's address and sets status bit 7. The interpreter is then in status mode.
- R4: If `wp` is high during the data write of a single program, the array is left unchanged and status bit 4 (program error) is set.
- R5: The sequence 0x20 then 0xD0 fills with 0xFFFF every word of the sector that holds the address of the 0xD0 write. That sector is the address aligned down to SECTOR_WORDS. Other sectors are not touched. The sequence 0x20 then 0xFF returns to array mode with no erase.
- R6: If `wp` is high during the 0xD0 of an erase, the array is left unchanged and status bit 5 (erase error) is set.
- R7: A command write of 0x50 clears status bits 5 and 4, keeps bit 7, and returns to array mode.
- R8: After 0x60, a second write of 0x01 or 0xD0 enters status mode. Any other second write returns to array mode.
- R9: While the active command is 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8, every read returns the status byte copied into each device lane. With DEV_BYTES=1 that is {status, status}; with DEV_BYTES=2 it is {0x00, status}.
- R10: After 0x90, a read at word address 0 returns MFR_ID, address 1 returns DEV_ID, and any other address returns 0.
- R11: After 0x98, a read returns the query byte in the low lane with the upper byte 0. The defined bytes are:
  - offsets 0x10, 0x11, 0x12: 0x51, 0x52, 0x59
  - offset 0x13: 0x01
  - offset 0x15: 0x31
  - offset 0x27: log2 of the array size in bytes
  - offset 0x28: 0x01
  - offset 0x2C: 0x01
  - offset 0x2D: sector count minus one
  - offset 0x2F: sector size in bytes shifted right by 8

  Every other offset, and every offset of 0x40 or above, reads 0. In identifier and query mode, the next write is decoded as a new command.
- R12: A write of 0xE8 sets status bit 7 and starts a buffered program. The next write gives N, the word count minus one, taken from the low 8*DEV_BYTES data bits. The following N+1 writes are each stored at their own address; the count drops by one after each of them except the last. A 0xD0 after that ends the sequence in status mode. Any other value at that point returns to array mode, and the words already written stay stored.
- R13: A first-cycle write whose low byte is 0xF0, 0xFF or any code not listed above returns to array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe; data on `rdata` next cycle |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wdata | input | 16 | Write data; low byte is the command code |
| wp | input | 1 | Write protect; blocks program and erase |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with DEPTH=64, SECTOR_WORDS=16, ADDR_W=8 and DEV_BYTES=1. That is small enough to program and read back every word, to check all 64 words after an erase for exact sector alignment, and to sweep the whole query space including offsets past the table. DEV_BYTES=1 makes status reads show the byte in both lanes. It also makes the buffered-program count take only the low byte of a write whose upper byte is non-zero, so the masking is observable in how many data writes are consumed.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    // Command codes decoded from the low byte of a bus write
    localparam logic [7:0] CMD_ARRAY   = 8'h00;
    localparam logic [7:0] CMD_PROG_A  = 8'h10;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_PROG_B  = 8'h40;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_BUFPROG = 8'hE8;
    localparam logic [7:0] ARG_CONFIRM = 8'hD0;
    localparam logic [7:0] ARG_LOCKSET = 8'h01;
    localparam logic [7:0] ARG_ABORT   = 8'hFF;

    // Status byte bit positions
    localparam int ST_READY    = 7;
    localparam int ST_ERASEERR = 5;
    localparam int ST_PROGERR  = 4;
    localparam logic [7:0] STATUS_RESET = 8'h80;

    // Query table geometry
    localparam int QRY_LEN = 64;
    localparam int QRY_AW  = $clog2(QRY_LEN);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARG,
        PH_DATA,
        PH_CONFIRM
    } phase_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_IDENT,
        RD_QUERY
    } rdmode_t;

    typedef struct packed {
        logic prog;
        logic erase;
    } arr_op_t;

    function automatic logic [7:0] qry_byte(
        input logic [QRY_AW-1:0] idx,
        input logic [7:0]        size_log2,
        input logic [7:0]        nsect_m1,
        input logic [7:0]        sect_hi
    );
        logic [7:0] b;
        case (idx)
            6'h10:   b = 8'h51;
            6'h11:   b = 8'h52;
            6'h12:   b = 8'h59;
            6'h13:   b = 8'h01;
            6'h15:   b = 8'h31;
            6'h27:   b = size_log2;
            6'h28:   b = 8'h01;
            6'h2C:   b = 8'h01;
            6'h2D:   b = nsect_m1;
            6'h2F:   b = sect_hi;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int DEV_BYTES = 1,
    localparam int CNT_W    = 8 * DEV_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] arg_bits,
    input  logic             wp,
    output arr_op_t          arr_op,
    output rdmode_t          rd_mode,
    output logic [7:0]       status
);

    logic [7:0]       cmd_q, cmd_d;
    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [7:0]       stat_q, stat_d;
    logic [7:0]       cbyte;

    assign cbyte = arg_bits[7:0];

    always_comb begin
        cmd_d   = cmd_q;
        phase_d = phase_q;
        cnt_d   = cnt_q;
        stat_d  = stat_q;
        arr_op  = '0;
        if (wr_en) begin
            case (phase_q)
                PH_IDLE: begin
                    case (cbyte)
                        CMD_PROG_A, CMD_PROG_B, CMD_ERASE, CMD_LOCK: begin
                            cmd_d   = cbyte;
                            phase_d = PH_ARG;
                        end
                        CMD_BUFPROG: begin
                            cmd_d            = cbyte;
                            phase_d          = PH_ARG;
                            stat_d[ST_READY] = 1'b1;
                        end
                        CMD_CLEAR: begin
                            stat_d[ST_ERASEERR] = 1'b0;
                            stat_d[ST_PROGERR]  = 1'b0;
                            cmd_d               = CMD_ARRAY;
                        end
                        CMD_STATUS, CMD_IDENT, CMD_QUERY: begin
                            cmd_d = cbyte;
                        end
                        default: begin
                            cmd_d   = CMD_ARRAY;
                            phase_d = PH_IDLE;
                        end
                    endcase
                end
                PH_ARG: begin
                    phase_d = PH_IDLE;
                    case (cmd_q)
                        CMD_PROG_A, CMD_PROG_B: begin
                            if (wp) stat_d[ST_PROGERR] = 1'b1;
                            else    arr_op.prog        = 1'b1;
                            stat_d[ST_READY] = 1'b1;
                        end
                        CMD_ERASE: begin
                            if (cbyte == ARG_CONFIRM) begin
                                if (wp) stat_d[ST_ERASEERR] = 1'b1;
                                else    arr_op.erase        = 1'b1;
                                stat_d[ST_READY] = 1'b1;
                            end else begin
                                cmd_d = CMD_ARRAY;
                            end
                        end
                        CMD_LOCK: begin
                            if (cbyte != ARG_LOCKSET && cbyte != ARG_CONFIRM)
                                cmd_d = CMD_ARRAY;
                        end
                        CMD_BUFPROG: begin
                            cnt_d   = arg_bits;
                            phase_d = PH_DATA;
                        end
                        default: cmd_d = CMD_ARRAY;
                    endcase
                end
                PH_DATA: begin
                    if (wp) stat_d[ST_PROGERR] = 1'b1;
                    else    arr_op.prog        = 1'b1;
                    if (cnt_q == '0) phase_d = PH_CONFIRM;
                    else             cnt_d   = cnt_q - CNT_W'(1);
                end
                PH_CONFIRM: begin
                    phase_d = PH_IDLE;
                    if (cbyte == ARG_CONFIRM) stat_d[ST_READY] = 1'b1;
                    else                      cmd_d            = CMD_ARRAY;
                end
                default: begin
                    phase_d = PH_IDLE;
                    cmd_d   = CMD_ARRAY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_ARRAY;
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            stat_q  <= STATUS_RESET;
        end else begin
            cmd_q   <= cmd_d;
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            stat_q  <= stat_d;
        end
    end

    always_comb begin
        case (cmd_q)
            CMD_ARRAY: rd_mode = RD_ARRAY;
            CMD_IDENT: rd_mode = RD_IDENT;
            CMD_QUERY: rd_mode = RD_QUERY;
            default:   rd_mode = RD_STATUS;
        endcase
    end

    assign status = stat_q;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stat_q == STATUS_RESET && cmd_q == CMD_ARRAY && phase_q == PH_IDLE)); // R1

    AST_PROG_PROTECT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp && phase_q == PH_ARG && (cmd_q == CMD_PROG_A || cmd_q == CMD_PROG_B))
        |=> stat_q[ST_PROGERR]); // R4

    AST_ERASE_PROTECT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp && phase_q == PH_ARG && cmd_q == CMD_ERASE && cbyte == ARG_CONFIRM)
        |=> stat_q[ST_ERASEERR]); // R6

    AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && phase_q == PH_IDLE && cbyte == CMD_CLEAR)
        |=> (stat_q[ST_ERASEERR:ST_PROGERR] == 2'b00 && stat_q[ST_READY] == $past(stat_q[ST_READY])
             && cmd_q == CMD_ARRAY)); // R7

    AST_BUF_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && phase_q == PH_DATA && cnt_q != '0)
        |=> (phase_q == PH_DATA && cnt_q == $past(cnt_q) - CNT_W'(1))); // R12

endmodule

// File: rtl/nor_cmd_array.sv
module nor_cmd_array
    import nor_cmd_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int SECTOR_WORDS = 16,
    localparam int MEM_AW      = $clog2(DEPTH),
    localparam int SEC_AW      = $clog2(SECTOR_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  arr_op_t           arr_op,
    input  logic [MEM_AW-1:0] addr,
    input  logic [15:0]       data,
    output logic [15:0]       rd_word
);

    logic [15:0] mem [DEPTH];
    logic [MEM_AW-SEC_AW-1:0] sect_sel;

    assign sect_sel = addr[MEM_AW-1:SEC_AW];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                mem[i] <= '1;
            else if (arr_op.erase && (i / SECTOR_WORDS) == int'(sect_sel))
                mem[i] <= '1;
            else if (arr_op.prog && i == int'(addr))
                mem[i] <= data;
        end
    end

    assign rd_word = mem[addr];

    AST_PROG_STORES: assert property (@(posedge clk) disable iff (rst)
        arr_op.prog |=> mem[$past(addr)] == $past(data)); // R3

    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (rst)
        arr_op.erase |=> (mem[{$past(sect_sel), SEC_AW'(0)}] == 16'hFFFF
                          && mem[{$past(sect_sel), {SEC_AW{1'b1}}}] == 16'hFFFF)); // R5

    AST_OP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(arr_op.prog && arr_op.erase)); // R5

endmodule

// File: rtl/nor_cmd_rdout.sv
module nor_cmd_rdout
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          DEV_BYTES    = 1,
    parameter int          DEPTH        = 64,
    parameter int          SECTOR_WORDS = 16,
    parameter logic [15:0] MFR_ID       = 16'h0089,
    parameter logic [15:0] DEV_ID       = 16'h0018,
    localparam logic [7:0] SIZE_LOG2    = 8'($clog2(DEPTH * 2)),
    localparam logic [7:0] NSECT_M1     = 8'(DEPTH / SECTOR_WORDS - 1),
    localparam logic [7:0] SECT_HI      = 8'((SECTOR_WORDS * 2) >> 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  rdmode_t           rd_mode,
    input  logic [7:0]        status,
    input  logic [15:0]       arr_word,
    output logic [15:0]       rdata
);

    logic [15:0] stat_word;
    logic [15:0] id_word;
    logic [15:0] qry_word;
    logic [15:0] sel_word;

    generate
        if (DEV_BYTES == 1) begin : g_lane_x8
            assign stat_word = {status, status};
        end else begin : g_lane_x16
            assign stat_word = {8'h00, status};
        end
    endgenerate

    always_comb begin
        if (addr == ADDR_W'(0))      id_word = MFR_ID;
        else if (addr == ADDR_W'(1)) id_word = DEV_ID;
        else                         id_word = 16'h0000;
    end

    always_comb begin
        if (addr >= ADDR_W'(QRY_LEN))
            qry_word = 16'h0000;
        else
            qry_word = {8'h00, qry_byte(addr[QRY_AW-1:0], SIZE_LOG2, NSECT_M1, SECT_HI)};
    end

    always_comb begin
        case (rd_mode)
            RD_ARRAY:  sel_word = arr_word;
            RD_STATUS: sel_word = stat_word;
            RD_IDENT:  sel_word = id_word;
            RD_QUERY:  sel_word = qry_word;
            default:   sel_word = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= sel_word;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R2

    AST_STATUS_LANE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_mode == RD_STATUS) |=> rdata[7:0] == $past(status)); // R9

    AST_ARRAY_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_mode == RD_ARRAY) |=> rdata == $past(arr_word)); // R2

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_cmd_pkg::*;
#(
    parameter int          DEPTH        = 64,
    parameter int          SECTOR_WORDS = 16,
    parameter int          ADDR_W       = 8,
    parameter int          DEV_BYTES    = 1,
    parameter logic [15:0] MFR_ID       = 16'h0089,
    parameter logic [15:0] DEV_ID       = 16'h0018,
    localparam int         MEM_AW       = $clog2(DEPTH),
    localparam int         CNT_W        = 8 * DEV_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              wp,
    output logic [15:0]       rdata
);

    arr_op_t     arr_op;
    rdmode_t     rd_mode;
    logic [7:0]  status;
    logic [15:0] arr_word;

    nor_cmd_seq #(
        .DEV_BYTES (DEV_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .arg_bits (wdata[CNT_W-1:0]),
        .wp       (wp),
        .arr_op   (arr_op),
        .rd_mode  (rd_mode),
        .status   (status)
    );

    nor_cmd_array #(
        .DEPTH        (DEPTH),
        .SECTOR_WORDS (SECTOR_WORDS)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .arr_op  (arr_op),
        .addr    (addr[MEM_AW-1:0]),
        .data    (wdata),
        .rd_word (arr_word)
    );

    nor_cmd_rdout #(
        .ADDR_W       (ADDR_W),
        .DEV_BYTES    (DEV_BYTES),
        .DEPTH        (DEPTH),
        .SECTOR_WORDS (SECTOR_WORDS),
        .MFR_ID       (MFR_ID),
        .DEV_ID       (DEV_ID)
    ) u_rdout (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .rd_mode  (rd_mode),
        .status   (status),
        .arr_word (arr_word),
        .rdata    (rdata)
    );

endmodule

// File: tb/nor_cmd_engine_test.sv
module nor_cmd_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int SECTOR     = 16;
    localparam logic [15:0] MFR = 16'h0089;
    localparam logic [15:0] DEV = 16'h0018;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wp = 1'b0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_cmd_engine uut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .wp    (wp),
        .rdata (rdata)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 16'h0101) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] qexp(input int a);
        case (a)
            16: return 16'h0051;
            17: return 16'h0052;
            18: return 16'h0059;
            19: return 16'h0001;
            21: return 16'h0031;
            39: return 16'h0007;
            40: return 16'h0001;
            44: return 16'h0001;
            45: return 16'(DEPTH / SECTOR - 1);
            47: return 16'((SECTOR * 2) / 256);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] q);
        @(negedge clk);
        rd_en = 1'b1; addr = 8'(a);
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sweep_array(input string tag);
        logic [15:0] q;
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, q);
            chk(tag, q, model[i]);
        end
    endtask

    initial begin
        logic [15:0] q;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, q); chk("R1 reset array read", q, 16'hFFFF);
        sweep_array("R1 erased after reset");
        wr(0, 16'h0070); rd(0, q); chk("R1 reset status", q, 16'h8080);
        wr(0, 16'h00FF);

        // R3: program every word with both program codes
        for (int i = 0; i < DEPTH; i++) begin
            wr(i, (i % 2 == 0) ? 16'h0010 : 16'h0040);
            wr(i, pat(i));
            model[i] = pat(i);
            if (i % 16 == 3) begin
                rd(i, q); chk("R3 status after program", q, 16'h8080);
            end
        end
        wr(0, 16'h00FF);
        sweep_array("R3 program readback");

        // R2: rdata holds without rd_en
        rd(5, q); chk("R2 array read", q, pat(5));
        repeat (3) @(negedge clk);
        wr(7, 16'h00FF);
        chk("R2 rdata hold", rdata, pat(5));

        // R5: erase sector containing word 37
        wr(37, 16'h0020); wr(37, 16'h00D0);
        rd(0, q); chk("R9 status during erase cmd", q, 16'h8080);
        wr(0, 16'h00FF);
        for (int i = 32; i < 48; i++) model[i] = 16'hFFFF;
        sweep_array("R5 sector erase");

        // R5: erase abort with 0xFF
        wr(3, 16'h0020); wr(3, 16'h00FF);
        rd(3, q); chk("R5 abort returns to array", q, model[3]);
        sweep_array("R5 abort leaves array");

        // R4: protected program
        wp = 1'b1;
        wr(10, 16'h0040); wr(10, 16'h1234);
        rd(10, q); chk("R4 program error status", q, 16'h9090);
        wr(0, 16'h00FF);
        rd(10, q); chk("R4 word unchanged", q, model[10]);

        // R7: clear status
        wr(0, 16'h0050);
        rd(10, q); chk("R7 array mode after clear", q, model[10]);
        wr(0, 16'h0070); rd(0, q); chk("R7 status cleared", q, 16'h8080);

        // R6: protected erase
        wr(0, 16'h0020); wr(0, 16'h00D0);
        rd(0, q); chk("R6 erase error status", q, 16'hA0A0);
        wr(0, 16'h00FF);
        for (int i = 0; i < SECTOR; i++) begin
            rd(i, q); chk("R6 sector unchanged", q, model[i]);
        end
        wp = 1'b0;
        wr(0, 16'h0050);

        // R8: lock / unlock sequences
        wr(0, 16'h0060); wr(0, 16'h0001);
        rd(2, q); chk("R8 lock enters status", q, 16'h8080);
        wr(0, 16'h0060); wr(0, 16'h00D0);
        rd(2, q); chk("R8 unlock enters status", q, 16'h8080);
        wr(0, 16'h0060); wr(0, 16'h0033);
        rd(2, q); chk("R8 bad lock arg to array", q, model[2]);

        // R10: identifier reads
        wr(0, 16'h0090);
        for (int a = 0; a < 8; a++) begin
            rd(a, q);
            chk("R10 ident", q, (a == 0) ? MFR : (a == 1) ? DEV : 16'h0000);
        end
        wr(0, 16'h00FF);

        // R11: query sweep including beyond the table
        wr(0, 16'h0098);
        for (int a = 0; a < 80; a++) begin
            rd(a, q); chk("R11 query byte", q, qexp(a));
        end
        wr(0, 16'h0070);
        rd(0, q); chk("R11 next write is command", q, 16'h8080);
        wr(0, 16'h00FF);

        // R12: buffered program, count masked to low byte (3 -> 4 words)
        wr(8, 16'h00E8);
        rd(8, q); chk("R12 status after start", q, 16'h8080);
        wr(8, 16'hAB03);
        for (int i = 8; i < 12; i++) begin
            wr(i, 16'hC000 + 16'(i));
            model[i] = 16'hC000 + 16'(i);
        end
        rd(8, q); chk("R12 status awaiting confirm", q, 16'h8080);
        wr(8, 16'h00D0);
        rd(8, q); chk("R12 status after confirm", q, 16'h8080);
        wr(0, 16'h00FF);
        for (int i = 8; i < 13; i++) begin
            rd(i, q); chk("R12 buffer readback", q, model[i]);
        end

        // R12: abort at confirm step
        wr(20, 16'h00E8); wr(20, 16'h0000); wr(20, 16'h7777);
        model[20] = 16'h7777;
        wr(20, 16'h0055);
        rd(20, q); chk("R12 abort to array", q, 16'h7777);

        // R13: leaving status mode
        wr(0, 16'h0070); wr(0, 16'h00F0);
        rd(4, q); chk("R13 F0 to array", q, model[4]);
        wr(0, 16'h0070); wr(0, 16'h1233);
        rd(4, q); chk("R13 unknown to array", q, model[4]);
        wr(0, 16'h0070); wr(0, 16'h00FF);
        rd(4, q); chk("R13 FF to array", q, model[4]);
        sweep_array("R13 final array");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule